// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is a down-counter that a processor drives through a small bank of word-wide registers on a simple synchronous bus. Software writes a reload value, which goes straight into the counter. It then issues a start command and waits for the timeout flag or for the level interrupt. The counter can run once and halt, or reload itself on every expiry to produce a periodic tick.

There are four word registers, and the word index is taken from the address bits above the two low bits. Offset 0x0 holds status: bit 0 is the timeout flag and bit 1 shows whether the counter is running. Offset 0x4 holds control: bit 0 is interrupt enable, bit 1 is auto-reload, bit 2 is a start command and bit 3 is a stop command. Offset 0x8 holds the reload value. Offset 0xC is a read-only view of the live count. A write to the status word clears the timeout flag, whatever data it carries. The interrupt output is high whenever a timeout is pending and interrupts are enabled.

Reads are combinational: the read data always reflects the currently addressed word. A write takes effect on the clock edge where the select and write-enable inputs are both high.

Top module: `cdt_timer`

## Requirements
- R1: Word index = address bits above bit 1. Indices 0..3 are status, control, reload and live count, and the two low address bits are ignored. Reads of any other index return zero, and writes to it change nothing.
- R2: After reset, all four readable words are zero, the counter is stopped and the interrupt output is low.
- R3: In the status word, bit 0 is the timeout flag and bit 1 is the running bit. A write of any data to the status word clears only the timeout flag.
- R4: A control write stores the full data word. If data bit 2 is set, the counter runs. If data bit 3 is set, the counter stops. With both bits set, the counter ends stopped.
- R5: A reload-register write stores the value and places it in the counter on the same edge, including while the counter is running.
- R6: While running, the count falls by one per clock. It expires on the edge where the count is 1 or 0 and sets the timeout flag. After a start edge, a loaded value N therefore expires max(N,1) edges later.
- R7: When auto-reload (control bit 1) is clear, expiry leaves the counter stopped with a count of zero.
- R8: When auto-reload is set, expiry reloads the counter from the reload register and keeps it running.
- R9: The interrupt output equals timeout flag AND control bit 0. It follows every register write and every expiry.
- R10: The live-count word returns the current count, and writes to it are ignored.
- R11: If an expiry and a status write fall on the same edge, the timeout flag ends set.
- R12: A stopped counter holds its count, and a later start resumes from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed word (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with an 8-bit data path and a 6-bit address. With an 8-bit data path, every reload value from 0 to 255 can be swept through a complete one-shot run, so the expiry edge is checked for each value, including the zero-count case. The 6-bit address gives twelve unmapped word indices, and the bench writes and reads every one of them. Auto-reload runs over reload values 1 to 20 bring within reach the case where a status clear lands on an expiry edge, along with stop, resume and reload-while-running sequences.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int STAT_TMO_BIT  = 0;
    localparam int STAT_RUN_BIT  = 1;
    localparam int CTL_IE_BIT    = 0;
    localparam int CTL_CONT_BIT  = 1;
    localparam int CTL_START_BIT = 2;
    localparam int CTL_STOP_BIT  = 3;
    localparam int CTL_USED_BITS = 4;

    typedef enum logic [1:0] {
        REG_STAT   = 2'd0,
        REG_CTRL   = 2'd1,
        REG_RELOAD = 2'd2,
        REG_LIVE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic stat;
        logic ctrl;
        logic reload;
    } wr_strobe_t;
endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_strobe_t        wr_o,
    output reg_sel_e          rsel_o,
    output logic              hit_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_lsbs;

    assign idx         = addr_i[ADDR_W-1:2];
    assign unused_lsbs = addr_i[1:0];
    assign rsel_o      = reg_sel_e'(idx[1:0]);

    generate
        if (IDX_W > 2) begin : g_wide
            assign hit_o = (idx[IDX_W-1:2] == '0);
        end else begin : g_exact
            assign hit_o = 1'b1;
        end
    endgenerate

    always_comb begin
        wr_o = '0;
        if (sel_i && we_i && hit_o) begin
            case (rsel_o)
                REG_STAT:   wr_o.stat   = 1'b1;
                REG_CTRL:   wr_o.ctrl   = 1'b1;
                REG_RELOAD: wr_o.reload = 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/cdt_ctrl_regs.sv
module cdt_ctrl_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl_i,
    input  logic              wr_reload_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic              ie_o,
    output logic              cont_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              load_o
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl_i)   regs_d.ctrl   = wdata_i;
        if (wr_reload_i) regs_d.reload = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_o   = regs_q.ctrl;
    assign reload_o = regs_q.reload;
    assign ie_o     = regs_q.ctrl[CTL_IE_BIT];
    assign cont_o   = regs_q.ctrl[CTL_CONT_BIT];
    assign start_o  = wr_ctrl_i & wdata_i[CTL_START_BIT];
    assign stop_o   = wr_ctrl_i & wdata_i[CTL_STOP_BIT];
    assign load_o   = wr_reload_i;

    AST_CTRL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_i |=> (ctrl_o == $past(wdata_i))); // R4
    AST_RELOAD_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload_i |=> (reload_o == $past(wdata_i))); // R5
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              cont_i,
    input  logic [DATA_W-1:0] reload_i,
    output logic [DATA_W-1:0] count_o,
    output logic              run_o,
    output logic              expire_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              run;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic at_end;

    assign at_end = (cnt_q.count <= ONE);

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.run) begin
            if (at_end) begin
                if (cont_i) begin
                    cnt_d.count = reload_i;
                end else begin
                    cnt_d.count = '0;
                    cnt_d.run   = 1'b0;
                end
            end else begin
                cnt_d.count = cnt_q.count - ONE;
            end
        end
        if (load_i)  cnt_d.count = load_val_i;
        if (start_i) cnt_d.run   = 1'b1;
        if (stop_i)  cnt_d.run   = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o  = cnt_q.count;
    assign run_o    = cnt_q.run;
    assign expire_o = cnt_q.run && at_end;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && (count_o > ONE) && !load_i) |=> (count_o == $past(count_o) - ONE)); // R6
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !cont_i && !start_i) |=> !run_o); // R7
    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && cont_i && !load_i && !stop_i) |=> (run_o && count_o == $past(reload_i))); // R8
    AST_STOP_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !run_o); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !load_i) |=> $stable(count_o)); // R12
    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i))); // R5
endmodule

// File: rtl/cdt_status.sv
module cdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic expire_i,
    input  logic ie_i,
    output logic tmo_o,
    output logic irq_o
);
    typedef struct packed {
        logic tmo;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)    st_d.tmo = 1'b0;
        if (expire_i) st_d.tmo = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_o = st_q.tmo;
    assign irq_o = st_q.tmo & ie_i;

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !expire_i) |=> !tmo_o); // R3
    AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> tmo_o); // R11
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    wr_strobe_t        wr;
    reg_sel_e          rsel;
    logic              hit;
    logic [DATA_W-1:0] ctrl, reload, count, stat_word;
    logic              ie, cont, start_cmd, stop_cmd, load;
    logic              run, expire, tmo;

    cdt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel_i  (bus_sel),
        .we_i   (bus_we),
        .addr_i (bus_addr),
        .wr_o   (wr),
        .rsel_o (rsel),
        .hit_o  (hit)
    );

    cdt_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr.ctrl),
        .wr_reload_i (wr.reload),
        .wdata_i     (bus_wdata),
        .ctrl_o      (ctrl),
        .reload_o    (reload),
        .ie_o        (ie),
        .cont_o      (cont),
        .start_o     (start_cmd),
        .stop_o      (stop_cmd),
        .load_o      (load)
    );

    cdt_counter #(.DATA_W(DATA_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (bus_wdata),
        .start_i    (start_cmd),
        .stop_i     (stop_cmd),
        .cont_i     (cont),
        .reload_i   (reload),
        .count_o    (count),
        .run_o      (run),
        .expire_o   (expire)
    );

    cdt_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (wr.stat),
        .expire_i (expire),
        .ie_i     (ie),
        .tmo_o    (tmo),
        .irq_o    (irq)
    );

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_TMO_BIT] = tmo;
        stat_word[STAT_RUN_BIT] = run;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (rsel)
                REG_STAT:   bus_rdata = stat_word;
                REG_CTRL:   bus_rdata = ctrl;
                REG_RELOAD: bus_rdata = reload;
                default:    bus_rdata = count;
            endcase
        end
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr.ctrl || expire)); // R9
    AST_RUN_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(start_cmd)); // R4
endmodule

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 6;
    localparam int A_STAT = 0, A_CTRL = 4, A_RELOAD = 8, A_LIVE = 12;
    localparam int B_TMO = 1, B_RUN = 2;
    localparam int C_IE = 1, C_CONT = 2, C_START = 4, C_STOP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdt_timer #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = AW'(a); bus_wdata = DW'(d);
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        bus_addr = AW'(a);
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        rd_chk("R2 status", A_STAT, 0);
        rd_chk("R2 ctrl", A_CTRL, 0);
        rd_chk("R2 reload", A_RELOAD, 0);
        rd_chk("R2 live", A_LIVE, 0);
        chk("R2 irq", int'(irq), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();

        // R6 R7 R9 R3: one-shot sweep of every reload value
        for (int p = 0; p < (1 << DW); p++) begin
            int n;
            int ie;
            n  = (p == 0) ? 1 : p;
            ie = p & 1;
            wr(A_RELOAD, p);
            rd_chk("R5 load on write", A_LIVE, p);
            wr(A_CTRL, C_START | ie);
            repeat (n - 1) @(posedge clk);
            #1;
            rd_chk("R6 running before expiry", A_STAT, B_RUN);
            rd_chk("R6 last count", A_LIVE, (p == 0) ? 0 : 1);
            @(posedge clk);
            #1;
            rd_chk("R7 one-shot halted with flag", A_STAT, B_TMO);
            rd_chk("R7 count zero", A_LIVE, 0);
            chk("R9 irq follows enable", int'(irq), ie);
            wr(A_STAT, p);
            rd_chk("R3 clear by any data", A_STAT, 0);
            chk("R9 irq after clear", int'(irq), 0);
        end

        // R8 R11: auto-reload sweep
        for (int p = 1; p <= 20; p++) begin
            wr(A_RELOAD, p);
            wr(A_CTRL, C_START | C_CONT | C_IE);
            repeat (p - 1) @(posedge clk);
            #1;
            rd_chk("R8 no flag before expiry", A_STAT, B_RUN);
            @(posedge clk);
            #1;
            rd_chk("R8 flag and still running", A_STAT, B_RUN | B_TMO);
            rd_chk("R8 reloaded count", A_LIVE, p);
            chk("R9 irq on periodic expiry", int'(irq), 1);
            wr(A_STAT, 0);
            if (p == 1) begin
                rd_chk("R11 expiry beats clear", A_STAT, B_RUN | B_TMO);
            end else begin
                rd_chk("R3 flag cleared, run kept", A_STAT, B_RUN);
                rd_chk("R8 counting after reload", A_LIVE, p - 1);
                repeat (p - 2) @(posedge clk);
                #1;
                rd_chk("R8 no flag mid period", A_STAT, B_RUN);
                @(posedge clk);
                #1;
                rd_chk("R8 second expiry", A_STAT, B_RUN | B_TMO);
            end
            wr(A_CTRL, C_STOP);
            rd_chk("R4 stop command", A_STAT, B_TMO);
            wr(A_STAT, 0);
        end

        // R12 R4: stop, hold, both commands
        wr(A_RELOAD, 50);
        wr(A_CTRL, C_START);
        repeat (10) @(posedge clk);
        #1;
        rd_chk("R6 count after ten edges", A_LIVE, 40);
        wr(A_CTRL, C_STOP);
        rd_chk("R4 stopped", A_STAT, 0);
        rd_chk("R12 count at stop", A_LIVE, 39);
        repeat (5) @(posedge clk);
        #1;
        rd_chk("R12 count held", A_LIVE, 39);
        wr(A_CTRL, C_START | C_STOP);
        rd_chk("R4 stop wins over start", A_STAT, 0);
        rd_chk("R4 control stored", A_CTRL, C_START | C_STOP);
        wr(A_CTRL, C_START);
        wr(A_CTRL, C_START | C_STOP);
        rd_chk("R4 both bits while running", A_STAT, 0);
        rd_chk("R12 one step then hold", A_LIVE, 38);

        // R5: reload write while running
        wr(A_CTRL, C_START);
        repeat (3) @(posedge clk);
        wr(A_RELOAD, 7);
        rd_chk("R5 immediate load", A_LIVE, 7);
        rd_chk("R5 stored", A_RELOAD, 7);
        repeat (6) @(posedge clk);
        #1;
        rd_chk("R5 runs from new value", A_STAT, B_RUN);
        @(posedge clk);
        #1;
        rd_chk("R6 expiry after new value", A_STAT, B_TMO);

        // R10: live-count writes ignored
        wr(A_RELOAD, 9);
        wr(A_LIVE, 85);
        rd_chk("R10 live unchanged", A_LIVE, 9);
        rd_chk("R10 reload unchanged", A_RELOAD, 9);
        rd_chk("R10 flag unchanged", A_STAT, B_TMO);

        // R9: enable toggling with pending flag
        wr(A_CTRL, C_IE);
        chk("R9 irq on enable", int'(irq), 1);
        rd_chk("R4 no start without bit", A_STAT, B_TMO);
        wr(A_CTRL, 0);
        chk("R9 irq off on disable", int'(irq), 0);
        wr(A_CTRL, C_IE);
        wr(A_STAT, 255);
        chk("R9 irq off on clear", int'(irq), 0);
        wr(A_CTRL, 0);

        // R1: unmapped words and low address bits
        for (int i = 4; i < (1 << (AW - 2)); i++) begin
            wr(i * 4, 255);
            rd_chk("R1 unmapped reads zero", i * 4 + (i & 3), 0);
            rd_chk("R1 reload untouched", A_RELOAD, 9);
            rd_chk("R1 live untouched", A_LIVE, 9);
        end
        rd_chk("R1 status untouched", A_STAT, 0);
        rd_chk("R1 ctrl untouched", A_CTRL, 0);
        rd_chk("R1 low bits ignored", A_RELOAD + 1, 9);

        // R2: reset while running
        wr(A_CTRL, C_START | C_CONT | C_IE);
        repeat (4) @(posedge clk);
        do_reset();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule